// File: doc/BRIEF.md
# Cartridge ROM and Save-RAM Address Decoder

This block takes a 24-bit processor address and decides whether it lands in cartridge ROM, in battery-backed save RAM, or in neither. When it lands in one of them, the block also produces a linear byte offset into that memory. The offset is not yet reduced to the real memory size, so a later mirror stage must fold it. The upper eight address bits form the bank number and the lower sixteen the address within the bank.

There are two ROM layouts, and a mode input picks one. In the narrow layout each bank contributes 32 KB of ROM, found in its upper half. In the wide layout each bank contributes 64 KB. The ROM size and the save-RAM size are configuration inputs. Together they decide whether save RAM is decoded at all and how wide its window is in the high banks. All outputs are registered, so a result appears one clock after its inputs.

Top module: `cart_addr_map`

## Requirements
- R1: With `map_wide`=0, any address whose bit 15 is 1 selects ROM with offset `{bank[6:0], addr[14:0]}`, unless a save-RAM rule also matches.
- R2: With `map_wide`=1, banks with bank bit 6 set (40–7F, C0–FF) select ROM over the whole bank, with offset `{bank[5:0], addr[15:0]}`.
- R3: With `map_wide`=1, banks with bank bit 6 clear (00–3F, 80–BF) select ROM only when address bit 15 is 1, using the same offset as R2, so they mirror the upper half of the matching 64 KB bank. When bit 15 is 0 these banks give no ROM select.
- R4: In both layouts, banks 20–3F and A0–BF at in-bank addresses 6000–7FFF select save RAM with offset `{bank[4:0], addr[12:0]}`.
- R5: Banks 70–7F select save RAM with offset `{bank[3:0], addr[14:0]}`, only for addresses below 8000, when `rom_size` is above 0x200000 or `ram_size` is above 0x8000. In all other cases these banks select save RAM over the whole bank with offset `{bank[3:0], addr[15:0]}`.
- R6: Banks F0–FF decode the same save-RAM window as R5 only when `map_wide`=0. When `map_wide`=1 these banks are ROM as in R2.
- R7: When `ram_size` is 0, no save-RAM window is decoded, and the ROM rules alone decide the outcome.
- R8: When an address matches both a ROM rule and a save-RAM rule, save RAM wins.
- R9: When an address matches no rule, both selects are 0 and `map_offset` is 0.
- R10: The outputs change on the clock edge after their inputs are applied. A synchronous reset clears both selects and the offset.
- R11: `rom_sel` and `ram_sel` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 24 | Processor address: bank in bits 23:16, in-bank address in bits 15:0 |
| map_wide | input | 1 | ROM layout select: 0 = 32 KB per bank, 1 = 64 KB per bank |
| rom_size | input | 25 | ROM size in bytes |
| ram_size | input | 25 | Save-RAM size in bytes (0 = no save RAM) |
| rom_sel | output | 1 | Registered: the address hits ROM |
| ram_sel | output | 1 | Registered: the address hits save RAM |
| map_offset | output | 24 | Registered linear offset into the selected memory, before mirroring |

## Verification
Every result is due exactly one rising edge after its inputs. The bench changes the address, mode and sizes on a falling edge and compares all three outputs on the next falling edge, which falls between the edge that captures the result and the edge that would replace it. The reset checks work the same way: reset is raised on a falling edge and the cleared outputs are read one falling edge later. Random addresses are biased toward the save-RAM banks and the 8000 boundary. Between them, directed cases cover each window edge, the size thresholds, and the difference between the two layouts in banks F0–FF.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  localparam int CM_AW = 24;
  localparam int CM_BW = 8;

  typedef enum logic {
    LAYOUT_NARROW = 1'b0,
    LAYOUT_WIDE   = 1'b1
  } layout_e;

  typedef struct packed {
    logic             hit;
    logic [CM_AW-1:0] off;
  } map_hit_t;

endpackage

// File: rtl/cart_size_policy.sv
module cart_size_policy #(
  parameter int SIZE_W        = 25,
  parameter int ROM_BIG_BYTES = 32'h0020_0000,
  parameter int RAM_BIG_BYTES = 32'h0000_8000
) (
  input  logic [SIZE_W-1:0] rom_size,
  input  logic [SIZE_W-1:0] ram_size,
  output logic              ram_present,
  output logic              half_window
);

  localparam logic [SIZE_W-1:0] ROM_LIMIT = SIZE_W'(ROM_BIG_BYTES);
  localparam logic [SIZE_W-1:0] RAM_LIMIT = SIZE_W'(RAM_BIG_BYTES);

  always_comb begin
    ram_present = (ram_size != '0);
    half_window = (rom_size > ROM_LIMIT) || (ram_size > RAM_LIMIT);
  end

endmodule

// File: rtl/cart_rom_decode.sv
module cart_rom_decode
  import cart_map_pkg::*;
(
  input  logic [CM_AW-1:0] addr,
  input  layout_e          layout,
  output map_hit_t         rom
);

  logic [CM_BW-1:0] bank;
  logic [15:0]      inbank;
  logic             upper_half;
  logic             full_bank;

  always_comb begin
    bank       = addr[CM_AW-1:16];
    inbank     = addr[15:0];
    upper_half = inbank[15];
    full_bank  = bank[6];
    rom.hit    = 1'b0;
    rom.off    = '0;
    if (layout == LAYOUT_WIDE) begin
      if (full_bank || upper_half) begin
        rom.hit = 1'b1;
        rom.off = {2'b00, bank[5:0], inbank};
      end
    end else begin
      if (upper_half) begin
        rom.hit = 1'b1;
        rom.off = {2'b00, bank[6:0], inbank[14:0]};
      end
    end
  end

endmodule

// File: rtl/cart_ram_decode.sv
module cart_ram_decode
  import cart_map_pkg::*;
(
  input  logic [CM_AW-1:0] addr,
  input  layout_e          layout,
  input  logic             ram_present,
  input  logic             half_window,
  output map_hit_t         ram
);

  logic [CM_BW-1:0] bank;
  logic [15:0]      inbank;
  logic [1:0]       low_hit;
  logic [1:0]       high_hit;
  logic             low_any;
  logic             high_any;
  logic             high_span_ok;

  assign bank   = addr[CM_AW-1:16];
  assign inbank = addr[15:0];

  // One decoder per half of the bank space (bank bit 7 clear / set).
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic half_match;
    logic high_allowed;
    assign half_match   = (bank[7] == h[0]);
    // Upper-half copy of the high window exists only in the narrow layout.
    assign high_allowed = (h == 0) ? 1'b1 : (layout == LAYOUT_NARROW);
    assign low_hit[h]   = half_match && (bank[6:5] == 2'b01) &&
                          (inbank[15:13] == 3'b011);
    assign high_hit[h]  = half_match && high_allowed && (bank[6:4] == 3'b111);
  end

  always_comb begin
    high_span_ok = half_window ? ~inbank[15] : 1'b1;
    low_any      = ram_present && (low_hit != 2'b00);
    high_any     = ram_present && (high_hit != 2'b00) && high_span_ok;
    ram.hit      = low_any || high_any;
    ram.off      = '0;
    if (low_any) begin
      ram.off = {6'd0, bank[4:0], inbank[12:0]};
    end else if (high_any) begin
      if (half_window) ram.off = {5'd0, bank[3:0], inbank[14:0]};
      else             ram.off = {4'd0, bank[3:0], inbank};
    end
  end

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
  import cart_map_pkg::*;
#(
  parameter int SIZE_W        = 25,
  parameter int ROM_BIG_BYTES = 32'h0020_0000,
  parameter int RAM_BIG_BYTES = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CM_AW-1:0]  cpu_addr,
  input  logic              map_wide,
  input  logic [SIZE_W-1:0] rom_size,
  input  logic [SIZE_W-1:0] ram_size,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic [CM_AW-1:0]  map_offset
);

  layout_e    layout;
  logic       ram_present;
  logic       half_window;
  map_hit_t   rom_hit;
  map_hit_t   ram_hit;
  logic       nxt_rom;
  logic       nxt_ram;
  logic [CM_AW-1:0] nxt_off;

  assign layout = map_wide ? LAYOUT_WIDE : LAYOUT_NARROW;

  cart_size_policy #(
    .SIZE_W       (SIZE_W),
    .ROM_BIG_BYTES(ROM_BIG_BYTES),
    .RAM_BIG_BYTES(RAM_BIG_BYTES)
  ) u_policy (
    .rom_size   (rom_size),
    .ram_size   (ram_size),
    .ram_present(ram_present),
    .half_window(half_window)
  );

  cart_rom_decode u_rom (
    .addr  (cpu_addr),
    .layout(layout),
    .rom   (rom_hit)
  );

  cart_ram_decode u_ram (
    .addr       (cpu_addr),
    .layout     (layout),
    .ram_present(ram_present),
    .half_window(half_window),
    .ram        (ram_hit)
  );

  // Save RAM outranks ROM where both decode.
  always_comb begin
    nxt_ram = ram_hit.hit;
    nxt_rom = rom_hit.hit && !ram_hit.hit;
    if (nxt_ram)      nxt_off = ram_hit.off;
    else if (nxt_rom) nxt_off = rom_hit.off;
    else              nxt_off = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel    <= 1'b0;
      ram_sel    <= 1'b0;
      map_offset <= '0;
    end else begin
      rom_sel    <= nxt_rom;
      ram_sel    <= nxt_ram;
      map_offset <= nxt_off;
    end
  end

  a_r11_one_select: assert property (@(posedge clk) disable iff (rst)
    !(rom_sel && ram_sel));

  a_r9_idle_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (!rom_sel && !ram_sel) |-> (map_offset == '0));

  a_r7_no_ram_when_empty: assert property (@(posedge clk) disable iff (rst)
    (ram_size == '0) |=> !ram_sel);

  a_r3_shadow_low_half: assert property (@(posedge clk) disable iff (rst)
    (map_wide && !cpu_addr[22] && !cpu_addr[15]) |=> !rom_sel);

  a_r1_narrow_lower_half: assert property (@(posedge clk) disable iff (rst)
    (!map_wide && !cpu_addr[15]) |=> !rom_sel);

  a_r4_low_window_is_ram: assert property (@(posedge clk) disable iff (rst)
    ((ram_size != '0) && (cpu_addr[22:21] == 2'b01) && (cpu_addr[15:13] == 3'b011))
      |=> (ram_sel && !rom_sel));

endmodule

// File: tb/sim_cart_addr_map.sv
`timescale 1ns/1ps
module sim_cart_addr_map;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cpu_addr = '0;
  logic        map_wide = 1'b0;
  logic [24:0] rom_size = 25'h010_0000;
  logic [24:0] ram_size = 25'h000_2000;
  logic        rom_sel;
  logic        ram_sel;
  logic [23:0] map_offset;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cart_addr_map u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .map_wide(map_wide),
    .rom_size(rom_size), .ram_size(ram_size),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .map_offset(map_offset)
  );

  // Expected triple plus the requirement tag that governs it.
  task automatic model(input logic [23:0] a, input logic w,
                       input logic [24:0] rs, input logic [24:0] ms,
                       output logic e_rom, output logic e_ram,
                       output logic [23:0] e_off, output string tag);
    int bank, lo, span;
    bit big, has_ram, rom_ok, ram_ok;
    int rom_o, ram_o;
    bank = int'(a[23:16]);
    lo   = int'(a[15:0]);
    big  = (rs > 25'h020_0000) || (ms > 25'h000_8000);
    has_ram = (ms != 0);
    rom_ok = 0; ram_ok = 0; rom_o = 0; ram_o = 0;
    tag = "R9";
    if (!w) begin
      if (lo >= 'h8000) begin rom_ok = 1; rom_o = (bank % 128) * 32768 + (lo - 'h8000); tag = "R1"; end
    end else if ((bank % 128) >= 'h40) begin
      rom_ok = 1; rom_o = (bank % 64) * 65536 + lo; tag = "R2";
    end else if (lo >= 'h8000) begin
      rom_ok = 1; rom_o = (bank % 64) * 65536 + lo; tag = "R3";
    end else tag = "R3";
    if ((bank % 128) >= 'h20 && (bank % 128) <= 'h3F && lo >= 'h6000 && lo <= 'h7FFF) begin
      if (has_ram) begin ram_ok = 1; ram_o = (bank % 32) * 8192 + (lo - 'h6000); tag = "R4"; end
      else tag = "R7";
    end
    if ((bank >= 'h70 && bank <= 'h7F) || (bank >= 'hF0 && !w)) begin
      span = big ? 32768 : 65536;
      if (!has_ram) tag = "R7";
      else if (lo < span) begin
        ram_ok = 1; ram_o = (bank % 16) * span + lo;
        tag = (bank >= 'hF0) ? "R6" : "R5";
      end else tag = "R5";
    end else if (bank >= 'hF0 && w) tag = "R6";
    if (ram_ok && rom_ok) tag = "R8";
    e_ram = ram_ok;
    e_rom = rom_ok && !ram_ok;
    e_off = ram_ok ? 24'(ram_o) : (rom_ok ? 24'(rom_o) : 24'd0);
  endtask

  task automatic check(input string tag, input logic e_rom, input logic e_ram,
                       input logic [23:0] e_off);
    n_checks++;
    if (rom_sel !== e_rom || ram_sel !== e_ram || map_offset !== e_off) begin
      n_fail++;
      $display("FAIL %s addr=%h wide=%0d rom=%h ram=%h: got rom_sel=%0d ram_sel=%0d off=%h, expected rom_sel=%0d ram_sel=%0d off=%h",
               tag, cpu_addr, map_wide, rom_size, ram_size, rom_sel, ram_sel, map_offset,
               e_rom, e_ram, e_off);
    end
    n_checks++;
    if (rom_sel && ram_sel) begin // R11
      n_fail++;
      $display("FAIL R11 both selects high: got 1/1, expected at most one");
    end
  endtask

  // Drive on a falling edge, compare on the next falling edge (R10: one register).
  task automatic apply(input logic [23:0] a, input logic w,
                       input logic [24:0] rs, input logic [24:0] ms);
    logic e_rom, e_ram;
    logic [23:0] e_off;
    string tag;
    cpu_addr = a; map_wide = w; rom_size = rs; ram_size = ms;
    model(a, w, rs, ms, e_rom, e_ram, e_off, tag);
    @(negedge clk);
    check(tag, e_rom, e_ram, e_off);
  endtask

  function automatic logic [24:0] pick_rom(input int k);
    case (k % 3)
      0: return 25'h010_0000;
      1: return 25'h020_0000;
      default: return 25'h040_0000;
    endcase
  endfunction

  function automatic logic [24:0] pick_ram(input int k);
    case (k % 4)
      0: return 25'h000_0000;
      1: return 25'h000_2000;
      2: return 25'h000_8000;
      default: return 25'h001_0000;
    endcase
  endfunction

  initial begin
    logic [24:0] rs, ms;
    logic [23:0] a;
    logic w;
    void'($urandom(32'd20240611));
    cpu_addr = 24'h00_8000;
    repeat (3) @(negedge clk);
    check("R10", 1'b0, 1'b0, 24'd0); // reset state
    rst = 1'b0;

    // R1 narrow layout
    apply(24'h00_8000, 1'b0, 25'h010_0000, 25'h000_2000);
    apply(24'h81_FFFF, 1'b0, 25'h010_0000, 25'h000_2000);
    apply(24'h00_7FFF, 1'b0, 25'h010_0000, 25'h000_2000);
    // R2 wide linear
    apply(24'h40_0000, 1'b1, 25'h040_0000, 25'h000_2000);
    apply(24'hC0_1234, 1'b1, 25'h040_0000, 25'h000_2000);
    // R3 wide shadow
    apply(24'h00_8000, 1'b1, 25'h040_0000, 25'h000_2000);
    apply(24'h01_FFFF, 1'b1, 25'h040_0000, 25'h000_2000);
    apply(24'h3F_5FFF, 1'b1, 25'h040_0000, 25'h000_2000);
    // R4 low save-RAM window edges
    apply(24'h20_6000, 1'b1, 25'h010_0000, 25'h000_2000);
    apply(24'hBF_7FFF, 1'b0, 25'h010_0000, 25'h000_2000);
    apply(24'h20_5FFF, 1'b0, 25'h010_0000, 25'h000_2000);
    // R5 / R8 high window span vs sizes
    apply(24'h70_8000, 1'b0, 25'h010_0000, 25'h000_2000);
    apply(24'h70_8000, 1'b0, 25'h010_0000, 25'h001_0000);
    apply(24'h70_8000, 1'b0, 25'h040_0000, 25'h000_2000);
    apply(24'h71_8000, 1'b1, 25'h040_0000, 25'h000_8000);
    apply(24'h7F_7FFF, 1'b1, 25'h040_0000, 25'h000_8000);
    apply(24'h7F_FFFF, 1'b1, 25'h020_0000, 25'h000_8000);
    // R6 top banks
    apply(24'hF0_0000, 1'b0, 25'h010_0000, 25'h000_2000);
    apply(24'hF0_0000, 1'b1, 25'h010_0000, 25'h000_2000);
    apply(24'hFF_FFFF, 1'b0, 25'h010_0000, 25'h000_2000);
    // R7 no save RAM
    apply(24'h20_6000, 1'b0, 25'h010_0000, 25'h000_0000);
    apply(24'h70_0000, 1'b0, 25'h010_0000, 25'h000_0000);
    apply(24'h70_8000, 1'b0, 25'h010_0000, 25'h000_0000);

    // R10 reset clears a live result
    cpu_addr = 24'h00_8000; map_wide = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10", 1'b0, 1'b0, 24'd0);
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      rs = pick_rom(int'($urandom % 3));
      ms = pick_ram(int'($urandom % 4));
      w  = 1'($urandom % 2);
      a  = 24'($urandom);
      case ($urandom % 4)
        0: a[23:16] = {a[23], 3'b111, a[19:16]};
        1: a[23:16] = {a[23], 2'b01, a[20:16]};
        2: a[15:0]  = (a[0]) ? 16'h8000 : 16'h7FFF;
        default: ;
      endcase
      apply(a, w, rs, ms);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule